// File: doc/BRIEF.md
# Lane Permute Unit

The lane permute unit rearranges the lanes of two wide operands, a source A and a source B, into one wide result. It serves a vector datapath: each issued operation names a routing by a 4-bit code and a destination register index, and one clock later the unit presents the permuted value together with a write enable and the destination index for the register file. The routings cover interleaving the low halves of both operands at byte, halfword or word size, interleaving their high words, packing their even words, copying the low or high 64-bit halves, replicating one halfword across each 64-bit half, and rotating the three low words of source B.

A destination index of zero means the result is discarded: the value still appears on the data output but the write enable stays low. Codes that name no routing produce a zero result and no write. With the issue strobe low the outputs return to zero with no write.

Word, halfword and byte numbering counts from the least significant end: word k of an operand occupies bits [32k+31:32k], halfword k bits [16k+15:16k], byte k bits [8k+7:8k].

Top module: `perm_unit`

## Requirements
- R1: While reset is asserted and after its release with no issue, out_we is 0, out_dst is 0 and out_data is 0.
- R2: Code 1 (pack even words) yields result words 0..3 = B word 0, B word 2, A word 0, A word 2.
- R3: Code 2 (byte interleave) takes bytes 0..7 of each operand; result byte 2i is B byte i and result byte 2i+1 is A byte i.
- R4: Code 3 (halfword interleave) takes halfwords 0..3 of each operand; result halfword 2i is B halfword i and 2i+1 is A halfword i.
- R5: Code 4 (low word interleave) yields result words 0..3 = B word 0, A word 0, B word 1, A word 1.
- R6: Code 5 (high word interleave) yields result words 0..3 = B word 2, A word 2, B word 3, A word 3.
- R7: Code 6 (halfword broadcast) fills all four halfwords of result bits [63:0] with B halfword 0 and all four of bits [127:64] with B halfword 4.
- R8: Code 7 (copy low halves) yields result[63:0] = B[63:0] and result[127:64] = A[63:0].
- R9: Code 8 (copy high halves) yields result[63:0] = A[127:64] and result[127:64] = B[127:64].
- R10: Code 9 (three-word rotate) yields result words 0..3 = B word 1, B word 2, B word 0, B word 3; word 3 passes through unchanged.
- R11: An issue with destination index 0 and a known code gives out_we = 0 and out_dst = 0 while out_data still carries the routed value.
- R12: An issue with code 0 or any code from 10 to 15 gives out_data = 0 and out_we = 0.
- R13: A cycle with in_valid low gives out_we = 0 and out_data = 0 on the next cycle.
- R14: Results appear exactly one clock after issue; an issue with a known code and nonzero destination gives out_we = 1 and out_dst equal to the issued index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the current operation |
| op | input | 4 | Routing code |
| dst | input | 5 | Destination register index; 0 discards the result |
| src_a | input | 128 | Operand A |
| src_b | input | 128 | Operand B |
| out_we | output | 1 | Write enable for the result, one cycle after issue |
| out_dst | output | 5 | Destination index accompanying the result |
| out_data | output | 128 | Permuted result |

## Verification
The properties assume every input is a known value at each rising edge while reset is released, and that the operands and code of an issue are meaningful only in the cycle in_valid is high; they relate the output of one cycle to the inputs of the cycle before. The bench changes inputs only on falling edges and holds them steady across the sampling edge, and it uses operands whose every byte carries a distinct value, so that any misrouted lane shows up in the compared result.

// File: rtl/perm_pkg.sv
package perm_pkg;

   localparam int unsigned OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NONE     = 4'd0,
      OP_PACK_EW  = 4'd1,
      OP_ILV_LB   = 4'd2,
      OP_ILV_LH   = 4'd3,
      OP_ILV_LW   = 4'd4,
      OP_ILV_HW   = 4'd5,
      OP_BCAST_H  = 4'd6,
      OP_COPY_LO  = 4'd7,
      OP_COPY_HI  = 4'd8,
      OP_ROT3_W   = 4'd9
   } perm_op_e;

   localparam int unsigned ILV_VARIANTS = 3;

   function automatic logic op_known(input logic [OP_W-1:0] code);
      return (code >= 4'd1) && (code <= 4'd9);
   endfunction

endpackage

// File: rtl/perm_interleave.sv
module perm_interleave #(
   parameter int unsigned IN_W   = 64,
   parameter int unsigned LANE_W = 8
) (
   input  logic [IN_W-1:0]   a_half,
   input  logic [IN_W-1:0]   b_half,
   output logic [2*IN_W-1:0] y
);
   localparam int unsigned N_LANES = IN_W / LANE_W;

   if (IN_W % LANE_W != 0) begin : g_chk_lane
      $error("perm_interleave: IN_W must be a multiple of LANE_W");
   end

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      assign y[(2*i)*LANE_W   +: LANE_W] = b_half[i*LANE_W +: LANE_W];
      assign y[(2*i+1)*LANE_W +: LANE_W] = a_half[i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/perm_word_route.sv
module perm_word_route #(
   parameter int unsigned DATA_W = 128
) (
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] pack_ew,
   output logic [DATA_W-1:0] bcast_h,
   output logic [DATA_W-1:0] copy_lo,
   output logic [DATA_W-1:0] copy_hi,
   output logic [DATA_W-1:0] rot3_w
);
   localparam int unsigned DW_W   = DATA_W / 2;
   localparam int unsigned WORD_W = DATA_W / 4;
   localparam int unsigned HW_W   = DATA_W / 8;
   localparam int unsigned HW_PER = DW_W / HW_W;

   assign pack_ew = {src_a[2*WORD_W +: WORD_W], src_a[0 +: WORD_W],
                     src_b[2*WORD_W +: WORD_W], src_b[0 +: WORD_W]};

   assign copy_lo = {src_a[0 +: DW_W], src_b[0 +: DW_W]};
   assign copy_hi = {src_b[DW_W +: DW_W], src_a[DW_W +: DW_W]};

   assign rot3_w  = {src_b[3*WORD_W +: WORD_W], src_b[0 +: WORD_W],
                     src_b[2*WORD_W +: WORD_W], src_b[WORD_W +: WORD_W]};

   for (genvar h = 0; h < 2; h++) begin : g_dw
      for (genvar k = 0; k < HW_PER; k++) begin : g_hw
         assign bcast_h[h*DW_W + k*HW_W +: HW_W] = src_b[h*DW_W +: HW_W];
      end
   end
endmodule

// File: rtl/perm_select.sv
module perm_select
   import perm_pkg::*;
#(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned DST_W  = 5
) (
   input  logic                    in_valid,
   input  logic [OP_W-1:0]         op,
   input  logic [DST_W-1:0]        dst,
   input  logic [DATA_W-1:0]       ilv [ILV_VARIANTS],
   input  logic [DATA_W-1:0]       ilv_hw,
   input  logic [DATA_W-1:0]       pack_ew,
   input  logic [DATA_W-1:0]       bcast_h,
   input  logic [DATA_W-1:0]       copy_lo,
   input  logic [DATA_W-1:0]       copy_hi,
   input  logic [DATA_W-1:0]       rot3_w,
   output logic [DATA_W-1:0]       nxt_data,
   output logic                    nxt_we,
   output logic [DST_W-1:0]        nxt_dst
);
   perm_op_e   op_e;
   logic       known;
   logic [DATA_W-1:0] routed;

   assign op_e  = perm_op_e'(op);
   assign known = op_known(op);

   always_comb begin
      case (op_e)
         OP_PACK_EW: routed = pack_ew;
         OP_ILV_LB:  routed = ilv[0];
         OP_ILV_LH:  routed = ilv[1];
         OP_ILV_LW:  routed = ilv[2];
         OP_ILV_HW:  routed = ilv_hw;
         OP_BCAST_H: routed = bcast_h;
         OP_COPY_LO: routed = copy_lo;
         OP_COPY_HI: routed = copy_hi;
         OP_ROT3_W:  routed = rot3_w;
         default:    routed = '0;
      endcase
   end

   always_comb begin
      nxt_data = (in_valid && known) ? routed : '0;
      nxt_we   = in_valid && known && (dst != '0);
      nxt_dst  = nxt_we ? dst : '0;
   end
endmodule

// File: rtl/perm_unit.sv
module perm_unit
   import perm_pkg::*;
#(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned DST_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [DST_W-1:0]  dst,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              out_we,
   output logic [DST_W-1:0]  out_dst,
   output logic [DATA_W-1:0] out_data
);
   localparam int unsigned HALF_W   = DATA_W / 2;
   localparam int unsigned BYTE_W   = DATA_W / 16;
   localparam int unsigned WORD_W   = DATA_W / 4;

   if (DATA_W % 64 != 0 || DATA_W < 64) begin : g_chk_width
      $error("perm_unit: DATA_W must be a nonzero multiple of 64");
   end
   if (DST_W < 1) begin : g_chk_dst
      $error("perm_unit: DST_W must be at least 1");
   end

   logic [DATA_W-1:0] ilv [ILV_VARIANTS];
   logic [DATA_W-1:0] ilv_hw;
   logic [DATA_W-1:0] pack_ew, bcast_h, copy_lo, copy_hi, rot3_w;
   logic [DATA_W-1:0] nxt_data;
   logic              nxt_we;
   logic [DST_W-1:0]  nxt_dst;

   // Low-half interleave at byte, halfword and word lane sizes
   for (genvar g = 0; g < ILV_VARIANTS; g++) begin : g_ilv
      perm_interleave #(.IN_W(HALF_W), .LANE_W(BYTE_W << g)) u_ilv (
         .a_half (src_a[0 +: HALF_W]),
         .b_half (src_b[0 +: HALF_W]),
         .y      (ilv[g])
      );
   end

   // High-half interleave at word size reuses the same lane router
   perm_interleave #(.IN_W(HALF_W), .LANE_W(WORD_W)) u_ilv_hi (
      .a_half (src_a[HALF_W +: HALF_W]),
      .b_half (src_b[HALF_W +: HALF_W]),
      .y      (ilv_hw)
   );

   perm_word_route #(.DATA_W(DATA_W)) u_route (
      .src_a   (src_a),
      .src_b   (src_b),
      .pack_ew (pack_ew),
      .bcast_h (bcast_h),
      .copy_lo (copy_lo),
      .copy_hi (copy_hi),
      .rot3_w  (rot3_w)
   );

   perm_select #(.DATA_W(DATA_W), .DST_W(DST_W)) u_sel (
      .in_valid (in_valid),
      .op       (op),
      .dst      (dst),
      .ilv      (ilv),
      .ilv_hw   (ilv_hw),
      .pack_ew  (pack_ew),
      .bcast_h  (bcast_h),
      .copy_lo  (copy_lo),
      .copy_hi  (copy_hi),
      .rot3_w   (rot3_w),
      .nxt_data (nxt_data),
      .nxt_we   (nxt_we),
      .nxt_dst  (nxt_dst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_we   <= 1'b0;
         out_dst  <= '0;
         out_data <= '0;
      end else begin
         out_we   <= nxt_we;
         out_dst  <= nxt_dst;
         out_data <= nxt_data;
      end
   end
endmodule

// File: rtl/perm_unit_chk.sv
module perm_unit_chk #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned DST_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        op,
   input logic [DST_W-1:0]  dst,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic              out_we,
   input logic [DST_W-1:0]  out_dst,
   input logic [DATA_W-1:0] out_data
);
   localparam int unsigned W = DATA_W / 4;
   localparam int unsigned D = DATA_W / 2;

   logic bad_code;
   assign bad_code = (op == 4'd0) || (op > 4'd9);

   // R2
   a_r2_pack_even: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd1) |=>
      out_data == {$past(src_a[2*W +: W]), $past(src_a[0 +: W]),
                   $past(src_b[2*W +: W]), $past(src_b[0 +: W])});

   // R8
   a_r8_copy_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd7) |=>
      out_data == {$past(src_a[0 +: D]), $past(src_b[0 +: D])});

   // R9
   a_r9_copy_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd8) |=>
      out_data == {$past(src_b[D +: D]), $past(src_a[D +: D])});

   // R10
   a_r10_rot3_top: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd9) |=>
      (out_data[3*W +: W] == $past(src_b[3*W +: W])) &&
      (out_data[0 +: W] == $past(src_b[W +: W])));

   // R11
   a_r11_dst_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst == '0) |=> (!out_we && out_dst == '0));

   // R12
   a_r12_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bad_code) |=> (!out_we && out_data == '0));

   // R13
   a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_we && out_data == '0));

   // R14
   a_r14_write: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !bad_code && dst != '0) |=> (out_we && out_dst == $past(dst)));
endmodule

bind perm_unit perm_unit_chk #(.DATA_W(DATA_W), .DST_W(DST_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op       (op),
   .dst      (dst),
   .src_a    (src_a),
   .src_b    (src_b),
   .out_we   (out_we),
   .out_dst  (out_dst),
   .out_data (out_data)
);

// File: tb/perm_unit_tb.sv
`timescale 1ns/1ps
module perm_unit_tb;
   localparam logic [127:0] PAT_A = 128'hAFAEADACABAAA9A8A7A6A5A4A3A2A1A0;
   localparam logic [127:0] PAT_B = 128'hBFBEBDBCBBBAB9B8B7B6B5B4B3B2B1B0;
   localparam int NV = 14;

   // op, swap operands (A<->B), destination, expected result
   localparam logic [3:0]   V_OP   [NV] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
                                          4'd8, 4'd9, 4'd1, 4'd2, 4'd9, 4'd6, 4'd5};
   localparam logic         V_SWAP [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam logic [4:0]   V_DST  [NV] = '{5'd1, 5'd2, 5'd3, 5'd31, 5'd5, 5'd6, 5'd7,
                                          5'd8, 5'd9, 5'd10, 5'd16, 5'd17, 5'd30, 5'd1};
   localparam logic [127:0] V_EXP  [NV] = '{
      128'hABAAA9A8A3A2A1A0BBBAB9B8B3B2B1B0,  // R2
      128'hA7B7A6B6A5B5A4B4A3B3A2B2A1B1A0B0,  // R3
      128'hA7A6B7B6A5A4B5B4A3A2B3B2A1A0B1B0,  // R4
      128'hA7A6A5A4B7B6B5B4A3A2A1A0B3B2B1B0,  // R5
      128'hAFAEADACBFBEBDBCABAAA9A8BBBAB9B8,  // R6
      128'hB9B8B9B8B9B8B9B8B1B0B1B0B1B0B1B0,  // R7
      128'hA7A6A5A4A3A2A1A0B7B6B5B4B3B2B1B0,  // R8
      128'hBFBEBDBCBBBAB9B8AFAEADACABAAA9A8,  // R9
      128'hBFBEBDBCB3B2B1B0BBBAB9B8B7B6B5B4,  // R10
      128'hBBBAB9B8B3B2B1B0ABAAA9A8A3A2A1A0,  // R2 swapped
      128'hB7A7B6A6B5A5B4A4B3A3B2A2B1A1B0A0,  // R3 swapped
      128'hAFAEADACA3A2A1A0ABAAA9A8A7A6A5A4,  // R10 swapped
      128'hA9A8A9A8A9A8A9A8A1A0A1A0A1A0A1A0,  // R7 swapped
      128'hAFAEADACBFBEBDBCABAAA9A8BBBAB9B8   // R6 repeat, back-to-back
   };
   localparam string V_REQ [NV] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8",
                                   "R9", "R10", "R2", "R3", "R10", "R7", "R6"};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   op = '0;
   logic [4:0]   dst = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         out_we;
   logic [4:0]   out_dst;
   logic [127:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   perm_unit u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .op       (op),
      .dst      (dst),
      .src_a    (src_a),
      .src_b    (src_b),
      .out_we   (out_we),
      .out_dst  (out_dst),
      .out_data (out_data)
   );

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic v, input logic [3:0] c, input logic [4:0] d,
                        input logic [127:0] a, input logic [127:0] b);
      @(negedge clk);
      in_valid = v;
      op       = c;
      dst      = d;
      src_a    = a;
      src_b    = b;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R14 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, during and just after reset
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "we in reset", {127'd0, out_we}, 128'd0);
      chk("R1", "data in reset", out_data, 128'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1", "dst after reset", {123'd0, out_dst}, 128'd0);
      chk("R1", "data after reset", out_data, 128'd0);

      // Table of routings, one per cycle
      for (int i = 0; i < NV; i++) begin
         issue(1'b1, V_OP[i], V_DST[i],
               V_SWAP[i] ? PAT_B : PAT_A, V_SWAP[i] ? PAT_A : PAT_B);
         chk(V_REQ[i], "data", out_data, V_EXP[i]);
         chk("R14", "we", {127'd0, out_we}, 128'd1);
         chk("R14", "dst", {123'd0, out_dst}, {123'd0, V_DST[i]});
      end

      // R11: destination zero discards the write, data still routed
      issue(1'b1, 4'd7, 5'd0, PAT_A, PAT_B);
      chk("R11", "we", {127'd0, out_we}, 128'd0);
      chk("R11", "dst", {123'd0, out_dst}, 128'd0);
      chk("R11", "data", out_data, 128'hA7A6A5A4A3A2A1A0B7B6B5B4B3B2B1B0);

      // R12: unknown codes at both ends of the unused range
      issue(1'b1, 4'd0, 5'd3, PAT_A, PAT_B);
      chk("R12", "data code 0", out_data, 128'd0);
      chk("R12", "we code 0", {127'd0, out_we}, 128'd0);
      issue(1'b1, 4'd10, 5'd3, PAT_A, PAT_B);
      chk("R12", "data code 10", out_data, 128'd0);
      issue(1'b1, 4'd15, 5'd4, PAT_A, PAT_B);
      chk("R12", "we code 15", {127'd0, out_we}, 128'd0);

      // R13: idle cycle with a valid-looking code on the bus
      issue(1'b0, 4'd7, 5'd4, PAT_A, PAT_B);
      chk("R13", "we", {127'd0, out_we}, 128'd0);
      chk("R13", "data", out_data, 128'd0);

      // R14: output unchanged before the edge, updated after it
      @(negedge clk);
      in_valid = 1'b1;
      op       = 4'd9;
      dst      = 5'd12;
      src_a    = PAT_A;
      src_b    = PAT_B;
      #1;
      chk("R14", "before edge", out_data, 128'd0);
      @(posedge clk);
      #1;
      chk("R14", "after edge", out_data, 128'hBFBEBDBCB3B2B1B0BBBAB9B8B7B6B5B4);
      chk("R14", "dst after edge", {123'd0, out_dst}, 128'd12);

      // R1: reset reasserted mid-stream clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "async clear", out_data, 128'd0);
      in_valid = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule